// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two unsigned operands with a single one-bit adder slice. It handles one bit position per clock. A pulse or level on `load` captures both operands in parallel into right-shifting registers. The same `load` clears the stored carry and arms a down-counter. After `load` drops, the operands move one place toward bit 0 on every clock. The adder slice combines the two low bits with the stored carry. Each resulting sum bit enters the top of a result register, so the lowest sum bit is produced first.

The down-counter stops all shifting after exactly `WIDTH` clocks. The result register then holds the complete sum, `carry_out` holds the carry out of the top bit, and `done` goes high. The result stays there until the next load. Raising `load` again at any time abandons the current addition and starts over with the new operands.

Top module: `bitser_adder`

## Requirements
- R1: After reset with `load` low, `sum` is 0, `carry_out` is 0 and `done` is 1.
- R2: `done` is 0 in every cycle in which `load` is 1. After the first clock edge at which `load` is sampled low, `done` stays 0 for the next WIDTH-1 edges and becomes 1 right after the WIDTH-th such edge.
- R3: When `done` rises, `sum` equals (A + B) mod 2^WIDTH and `carry_out` equals bit WIDTH of A + B, where A and B are the operands present at the last edge with `load` high.
- R4: A carry left over from an earlier addition never enters a new one: `load` clears the stored carry.
- R5: While `done` is 1, `sum` and `carry_out` hold their values. Changes on `op_a` and `op_b` have no effect on them.
- R6: Raising `load` in the middle of an addition abandons it. `done` does not rise for the abandoned operands, and the new operands produce a correct result.
- R7: Operands are consumed from bit 0 upward. After k shift edges (1 ≤ k ≤ WIDTH), `sum` shifted right by WIDTH-k equals the low k bits of A + B.
- R8: Holding `load` high for several cycles captures the operands present at the last edge with `load` high. Counting starts only after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load | input | 1 | Capture operands, clear carry, restart the count |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum | output | WIDTH | Result register (low WIDTH bits of the sum) |
| carry_out | output | 1 | Stored carry; after completion, the carry out of the top bit |
| done | output | 1 | High when the count is exhausted and `load` is low |

## Verification
The bench adds 0xFF and 0x01 and then adds two zeros. A design that fails to clear the carry on load returns 1 instead of 0 for the second addition. It samples `done` on every edge after release, which catches a count that is off by one. It also compares the upper bits of `sum` after each shift, which exposes a design that consumes the operands from the most significant bit first. The bench also reloads in the middle of an addition and holds `load` over several changing operand values. A design that does not restart in these cases reports a stale sum or raises `done` early. Finally, it toggles the operand inputs while idle to catch a result register that keeps shifting after completion.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam int DEF_WIDTH = 8;

  // one-bit adder slice result
  typedef struct packed {
    logic cy;
    logic s;
  } slice_t;

  function automatic slice_t add_slice(input logic a, input logic b, input logic c);
    slice_t r;
    r.s  = a ^ b ^ c;
    r.cy = (a & b) | (a & c) | (b & c);
    return r;
  endfunction
endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  // parallel load wins over shift; otherwise hold
  always_comb begin
    if (ld)      q_nxt = par_in;
    else if (en) q_nxt = {ser_in, q[WIDTH-1:1]};
    else         q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/bsa_carry.sv
module bsa_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a_bit,
  input  logic b_bit,
  output logic s_bit,
  output logic c_q
);
  import bsa_pkg::*;

  slice_t slice;
  logic   c_nxt;

  always_comb begin
    slice = add_slice(a_bit, b_bit, c_q);
    s_bit = slice.s;
    if (clr)     c_nxt = 1'b0;
    else if (en) c_nxt = slice.cy;
    else         c_nxt = c_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= 1'b0;
    else        c_q <= c_nxt;
  end

  // R4
  carry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (c_q == 1'b0));
endmodule

// File: rtl/bsa_countdown.sv
module bsa_countdown #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic run
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] START = CW'(WIDTH);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (load)              cnt_nxt = START;
    else if (cnt_q != '0)  cnt_nxt = cnt_q - 1'b1;
    else                   cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign run = |cnt_q;

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == START));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
  parameter int WIDTH = bsa_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             done
);
  logic [WIDTH-1:0] opa_q, opb_q, sum_q;
  logic             run, shift_en, s_bit;

  assign shift_en = run & ~load;

  bsa_countdown #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run)
  );

  bsa_shreg #(.WIDTH(WIDTH)) u_opa (
    .clk(clk), .rst_n(rst_n), .ld(load), .en(shift_en),
    .ser_in(1'b0), .par_in(op_a), .q(opa_q)
  );

  bsa_shreg #(.WIDTH(WIDTH)) u_opb (
    .clk(clk), .rst_n(rst_n), .ld(load), .en(shift_en),
    .ser_in(1'b0), .par_in(op_b), .q(opb_q)
  );

  bsa_carry u_cy (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(shift_en),
    .a_bit(opa_q[0]), .b_bit(opb_q[0]), .s_bit(s_bit), .c_q(carry_out)
  );

  bsa_shreg #(.WIDTH(WIDTH)) u_sum (
    .clk(clk), .rst_n(rst_n), .ld(1'b0), .en(shift_en),
    .ser_in(s_bit), .par_in('0), .q(sum_q)
  );

  assign sum  = sum_q;
  assign done = ~run & ~load;

  // R5
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(sum_q) && $stable(carry_out)));
  // R2
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load) |-> !done);
  // R7
  operand_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (opa_q == '0 && opb_q == '0));
endmodule

// File: tb/bitser_adder_bench.sv
`timescale 1ns/1ps
module bitser_adder_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] sum;
  logic         carry_out, done;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [W:0] exp_q[$];

  always #10 clk = ~clk;

  bitser_adder #(.WIDTH(W)) u_bitser_adder (
    .clk(clk), .rst_n(rst_n), .load(load), .op_a(op_a), .op_b(op_b),
    .sum(sum), .carry_out(carry_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // shift phase after release, checking done timing (R2) and LSB-first order (R7)
  task automatic shift_phase(input logic [W:0] e);
    for (int k = 1; k <= W; k++) begin
      @(posedge clk); #2;
      chk(done == (k == W), "R2 done timing", done, (k == W));
      chk(((sum >> (W - k)) & ((1 << k) - 1)) == (e & ((1 << k) - 1)),
          "R7 partial sum", int'(sum >> (W - k)), int'(e & ((1 << k) - 1)));
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] e;
    e = {1'b0, a} + {1'b0, b};
    @(negedge clk); load = 1'b1; op_a = a; op_b = b;
    @(posedge clk); #2;
    chk(!done, "R2 done low during load", done, 0);
    exp_q.push_back(e);
    @(negedge clk); load = 1'b0;
    shift_phase(e);
  endtask

  // scoreboard monitor: compare on each rising edge of done
  initial begin
    bit prev;
    prev = 1'b1;
    forever begin
      @(posedge clk); #2;
      if (mon_on) begin
        if (done && !prev) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected completion", sum, 0);
          end else begin
            logic [W:0] e;
            e = exp_q.pop_front();
            chk(sum == e[W-1:0], "R3 sum", sum, e[W-1:0]);
            chk(carry_out == e[W], "R3 carry_out", carry_out, e[W]);
          end
        end
        prev = done;
      end
    end
  end

  initial begin
    #(20ns * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [W-1:0] ra, rb, hs, lfsr;
    logic         hc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1
    chk(sum == '0, "R1 reset sum", sum, 0);
    chk(carry_out == 1'b0, "R1 reset carry", carry_out, 0);
    chk(done == 1'b1, "R1 reset done", done, 1);
    mon_on = 1'b1;

    // R3 basic patterns
    run_op(8'h0A, 8'h0F);
    run_op(8'hAA, 8'h55);
    run_op(8'h80, 8'h80);
    // R4 stale carry must not leak
    run_op(8'hFF, 8'h01);
    run_op(8'h00, 8'h00);
    chk(carry_out == 1'b0 && sum == '0, "R4 carry cleared", {carry_out, sum}, 0);

    // R5 hold while idle, operand inputs ignored
    run_op(8'hC3, 8'h7E);
    hs = sum; hc = carry_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); op_a = 8'(i * 37 + 5); op_b = 8'(i * 91 + 3);
    end
    @(posedge clk); #2;
    chk(sum == hs, "R5 sum held", sum, hs);
    chk(carry_out == hc, "R5 carry held", carry_out, hc);
    chk(done, "R5 done held", done, 1);

    // R6 abandon mid-operation
    @(negedge clk); load = 1'b1; op_a = 8'h11; op_b = 8'h22;
    @(negedge clk); load = 1'b0;
    repeat (3) @(posedge clk);
    #2 chk(!done, "R6 done low mid-run", done, 0);
    run_op(8'hF0, 8'h3C);

    // R8 load held across changing operands
    @(negedge clk); load = 1'b1; op_a = 8'h01; op_b = 8'h01;
    @(negedge clk); op_a = 8'h99; op_b = 8'h99;
    @(negedge clk); op_a = 8'h64; op_b = 8'hC8;
    @(posedge clk); #2;
    chk(!done, "R8 done low while held", done, 0);
    exp_q.push_back(9'h064 + 9'h0C8);
    @(negedge clk); load = 1'b0;
    shift_phase(9'h064 + 9'h0C8);

    // mixed patterns
    lfsr = 8'hB5;
    for (int i = 0; i < 12; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ra = lfsr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rb = lfsr ^ 8'h3A;
      run_op(ra, rb);
    end
    run_op(8'hFF, 8'hFF);

    repeat (3) @(posedge clk);
    #2 chk(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule